// File: doc/BRIEF.md
# Segmented Multi-Section Serial Shift Register

This block holds four serial shift sections that run from one shared clock. Two sections are four stages deep and two are five stages deep. Each five-stage section also brings out the bit held in its fourth stage. Data move one stage on every falling clock edge. Between falling edges every stage keeps its value, whether the clock rests high or low.

One further output is a copy of the first four-stage section's output, retimed on the rising edge. It therefore lags that output by half a clock period. A downstream register can take this copy when clock edges are slow, so that cascading stays safe.

A link-select input joins the four sections inside the block into a single 18-stage path, in the order A, B, C, D. Without the link, the sections can still be wired in series outside the block to build lengths from 4 to 18 stages. A synchronous active-high reset, sampled on the falling edge, clears every stage. The retimed copy is cleared on the rising edge.

Top module: `shsr_bank`

## Requirements
- R1: With link_all low, din_a and din_c reach dout_a and dout_c after exactly 4 falling edges, and din_b and din_d reach dout_b and dout_d after exactly 5 falling edges. Each section is independent of the others.
- R2: tap_b and tap_d carry the bit that entered their section 4 falling edges earlier. On the next falling edge, that bit moves to the section's output.
- R3: Stage contents change only on falling edges. A rising edge leaves dout_a..dout_d, tap_b and tap_d unchanged.
- R4: All sections shift on the same falling edge, so the same inputs applied to sections of equal length give equal outputs on the same cycle.
- R5: dout_a_late takes the value of dout_a on each rising edge. From a falling edge until the next rising edge, it therefore still shows the value dout_a had before that falling edge.
- R6: With link_all high, section B is fed from dout_a, C from dout_b, and D from dout_c. din_b, din_c and din_d are then ignored, and a bit on din_a appears on dout_d after exactly 18 falling edges. It appears on tap_d after 17 edges, on dout_c after 13 and on dout_b after 9.
- R7: rst high at a falling edge clears every stage to 0. rst high at a rising edge clears dout_a_late to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared shift clock; stages shift on its falling edge |
| rst | input | 1 | Synchronous active-high clear |
| link_all | input | 1 | 1 joins the sections A-B-C-D into one path |
| din_a | input | 1 | Serial input of four-stage section A |
| din_b | input | 1 | Serial input of five-stage section B |
| din_c | input | 1 | Serial input of four-stage section C |
| din_d | input | 1 | Serial input of five-stage section D |
| dout_a | output | 1 | Last-stage output of section A |
| dout_b | output | 1 | Last-stage output of section B |
| tap_b | output | 1 | Fourth-stage output of section B |
| dout_c | output | 1 | Last-stage output of section C |
| dout_d | output | 1 | Last-stage output of section D |
| tap_d | output | 1 | Fourth-stage output of section D |
| dout_a_late | output | 1 | dout_a retimed on the rising edge |

## Verification
On every cycle, the assertions check four things:
- the tap-to-output step of the five-stage sections;
- the clearing of stages and of the retimed copy;
- the retimed copy matching dout_a across each falling edge;
- the internal link from A into B whenever link_all was high.

Only the bench's scenarios show the rest. These are the full delays of 4, 5 and 18 edges, the ignoring of din_b..din_d while the sections are linked, and the absence of any change on rising edges. The bench checks each of these against its own per-section reference model.

// File: rtl/shsr_pkg.sv
package shsr_pkg;
  localparam int SHORT_LEN = 4;
  localparam int LONG_LEN  = 5;
  localparam int TAP_AT    = 4;

  function automatic int chain_len(input int s_len, input int l_len);
    return 2 * s_len + 2 * l_len;
  endfunction
endpackage

// File: rtl/shsr_section.sv
module shsr_section #(
  parameter int LEN = 4,
  parameter int TAP = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic dtap
);
  logic [LEN-1:0] sr_q;

  always_ff @(negedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[LEN-2:0], din};
  end

  assign dout = sr_q[LEN-1];

  generate
    if (TAP > 0) begin : g_tap
      assign dtap = sr_q[TAP-1];
      if (TAP == LEN - 1) begin : g_tap_chk
        AST_TAP_TO_OUT: assert property (@(negedge clk) disable iff (rst)
          !$past(rst) |-> (dout == $past(dtap))); // R2
      end
    end else begin : g_notap
      assign dtap = 1'b0;
    end
  endgenerate

  AST_SECTION_CLEAR: assert property (@(negedge clk)
    rst |=> (sr_q == '0)); // R7
endmodule

// File: rtl/shsr_halfcycle.sv
module shsr_halfcycle (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  AST_LATE_CLEAR: assert property (@(posedge clk)
    rst |=> (q == 1'b0)); // R7
endmodule

// File: rtl/shsr_bank.sv
module shsr_bank #(
  parameter int SHORT_LEN = shsr_pkg::SHORT_LEN,
  parameter int LONG_LEN  = shsr_pkg::LONG_LEN,
  parameter int TAP_AT    = shsr_pkg::TAP_AT
) (
  input  logic clk,
  input  logic rst,
  input  logic link_all,
  input  logic din_a,
  input  logic din_b,
  input  logic din_c,
  input  logic din_d,
  output logic dout_a,
  output logic dout_b,
  output logic tap_b,
  output logic dout_c,
  output logic dout_d,
  output logic tap_d,
  output logic dout_a_late
);
  localparam int TOTAL = shsr_pkg::chain_len(SHORT_LEN, LONG_LEN);

  logic feed_b, feed_c, feed_d;
  logic unused_a_tap, unused_c_tap;

  assign feed_b = link_all ? dout_a : din_b;
  assign feed_c = link_all ? dout_b : din_c;
  assign feed_d = link_all ? dout_c : din_d;

  shsr_section #(.LEN(SHORT_LEN), .TAP(0)) u_a (
    .clk(clk), .rst(rst), .din(din_a), .dout(dout_a), .dtap(unused_a_tap));
  shsr_section #(.LEN(LONG_LEN), .TAP(TAP_AT)) u_b (
    .clk(clk), .rst(rst), .din(feed_b), .dout(dout_b), .dtap(tap_b));
  shsr_section #(.LEN(SHORT_LEN), .TAP(0)) u_c (
    .clk(clk), .rst(rst), .din(feed_c), .dout(dout_c), .dtap(unused_c_tap));
  shsr_section #(.LEN(LONG_LEN), .TAP(TAP_AT)) u_d (
    .clk(clk), .rst(rst), .din(feed_d), .dout(dout_d), .dtap(tap_d));

  shsr_halfcycle u_late (
    .clk(clk), .rst(rst), .d(dout_a), .q(dout_a_late));

  initial begin
    assert (TOTAL >= 4) else $error("section lengths too small");
  end

  AST_LATE_FOLLOWS: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> (dout_a_late == dout_a)); // R5

  AST_CHAIN_LINK: assert property (@(negedge clk) disable iff (rst)
    (!$past(rst) && $past(link_all)) |-> (u_b.sr_q[0] == $past(dout_a))); // R6
endmodule

// File: tb/shsr_bank_test.sv
`timescale 1ns/1ps
module shsr_bank_test;
  logic clk = 1'b0;
  logic rst, link_all, din_a, din_b, din_c, din_d;
  logic dout_a, dout_b, tap_b, dout_c, dout_d, tap_d, dout_a_late;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  // reference model, one register per section
  logic [3:0] m_a, m_c;
  logic [4:0] m_b, m_d;

  always #2.5 clk = ~clk;

  shsr_bank uut (
    .clk(clk), .rst(rst), .link_all(link_all),
    .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
    .dout_a(dout_a), .dout_b(dout_b), .tap_b(tap_b), .dout_c(dout_c),
    .dout_d(dout_d), .tap_d(tap_d), .dout_a_late(dout_a_late));

  // {link_all, din_d, din_c, din_b, din_a}
  localparam logic [4:0] VEC [0:31] = '{
    5'h01, 5'h02, 5'h04, 5'h08, 5'h0F, 5'h00, 5'h05, 5'h0A,
    5'h03, 5'h0C, 5'h09, 5'h06, 5'h0F, 5'h0E, 5'h01, 5'h00,
    5'h11, 5'h1E, 5'h10, 5'h1F, 5'h10, 5'h11, 5'h1A, 5'h15,
    5'h10, 5'h1B, 5'h10, 5'h11, 5'h07, 5'h08, 5'h0D, 5'h02};

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic chk_outputs(input string tag);
    chk({tag, " R1 dout_a"}, dout_a, m_a[3]);
    chk({tag, " R1 dout_b"}, dout_b, m_b[4]);
    chk({tag, " R2 tap_b"},  tap_b,  m_b[3]);
    chk({tag, " R1 dout_c"}, dout_c, m_c[3]);
    chk({tag, " R1 dout_d"}, dout_d, m_d[4]);
    chk({tag, " R2 tap_d"},  tap_d,  m_d[3]);
  endtask

  // inputs are applied just after a rising edge
  task automatic step(input logic [4:0] v);
    logic ib, ic, id, prev_a;
    {link_all, din_d, din_c, din_b, din_a} = v;
    ib = v[4] ? m_a[3] : v[1];
    ic = v[4] ? m_b[4] : v[2];
    id = v[4] ? m_c[3] : v[3];
    prev_a = m_a[3];
    @(negedge clk);
    m_a = {m_a[2:0], v[0]};
    m_b = {m_b[3:0], ib};
    m_c = {m_c[2:0], ic};
    m_d = {m_d[3:0], id};
    #1;
    chk_outputs(v[4] ? "R6 chain" : "R4 indep");
    chk("R5 late before rise", dout_a_late, prev_a);
    @(posedge clk);
    #1;
    chk("R5 late after rise", dout_a_late, m_a[3]);
    chk_outputs("R3 after rise");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; link_all = 1'b0;
    din_a = 1'b0; din_b = 1'b0; din_c = 1'b0; din_d = 1'b0;
    m_a = '0; m_b = '0; m_c = '0; m_d = '0;
    @(negedge clk); @(negedge clk);
    @(posedge clk); #1;
    chk_outputs("R7 reset");
    chk("R7 late reset", dout_a_late, 1'b0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < 32; i++) step(VEC[i]);

    // R7: clear in the middle of traffic
    for (int i = 0; i < 6; i++) step(5'h0F);
    rst = 1'b1;
    @(negedge clk); #1;
    m_a = '0; m_b = '0; m_c = '0; m_d = '0;
    chk_outputs("R7 mid clear");
    @(posedge clk); #1;
    chk("R7 late mid clear", dout_a_late, 1'b0);
    rst = 1'b0;

    // R6: single pulse through the 18-stage path, other inputs toggling
    step(5'h11);
    for (int i = 2; i <= 18; i++) begin
      step((i % 2 == 0) ? 5'h1E : 5'h10);
      if (i == 9)  chk("R6 pulse at dout_b after 9", dout_b, 1'b1);
      if (i == 13) chk("R6 pulse at dout_c after 13", dout_c, 1'b1);
      if (i == 17) begin
        chk("R6 pulse at tap_d after 17", tap_d, 1'b1);
        chk("R6 dout_d still low after 17", dout_d, 1'b0);
      end
      if (i == 18) chk("R6 pulse at dout_d after 18", dout_d, 1'b1);
    end

    // R1: independent delays of 4 and 5, pulse on every input at once
    rst = 1'b1; @(negedge clk); @(posedge clk); #1; rst = 1'b0;
    m_a = '0; m_b = '0; m_c = '0; m_d = '0;
    step(5'h0F);
    for (int i = 2; i <= 5; i++) begin
      step(5'h00);
      if (i == 4) begin
        chk("R1 dout_a after 4", dout_a, 1'b1);
        chk("R1 dout_c after 4", dout_c, 1'b1);
        chk("R2 tap_b after 4", tap_b, 1'b1);
        chk("R1 dout_b low after 4", dout_b, 1'b0);
      end
      if (i == 5) begin
        chk("R1 dout_b after 5", dout_b, 1'b1);
        chk("R1 dout_d after 5", dout_d, 1'b1);
        chk("R1 dout_a cleared after 5", dout_a, 1'b0);
      end
    end

    finish_run();
  end
endmodule